// File: doc/BRIEF.md
# Cycle Count and Compare Timer with Gated Event Counters

This block keeps a free-running cycle counter that steps once for every cycle-advance strobe, and a compare register against which that counter is watched. While the interrupt-mask input is high and the counter sits inside a fixed window of 1000 counts starting at the compare value, the block holds a timer request high and presents a fixed cause code beside it. Two event counters run next to the main counter. Each advances on the same strobe, but only while one shared control register both sets its global enable bit and selects the cycle event in that counter's own select field.

Software loads the main counter, the compare value, the control register and either event counter through plain write strobes with data. A write lands on the next clock edge and takes precedence over an advance that arrives in the same cycle. Every port is a single-cycle strobe or a level, with no stream traffic. For that reason the block has no valid/ready pairs and never applies back-pressure: a write is taken on the edge where its strobe is high. Arbitration between interrupt sources and exception entry belong to the surrounding core.

Top module: `cop_timer_unit`

## Requirements
- R1: After reset every counter, the compare register and the control register read zero.
- R2: Each clock edge with `tick_i` high raises `count_o` by one, wrapping from 0xFFFFFFFF to 0. Without `tick_i`, `count_o` holds.
- R3: When `cnt_we_i` is high, `count_o` takes `cnt_wdata_i` on that edge, whatever the value of `tick_i`.
- R4: `pc0_o` advances by one on a `tick_i` edge only when control bit 31 is 1 and control bits 9:5 equal 1. Otherwise it holds. Other control bits have no effect on it.
- R5: `pc1_o` advances by one on a `tick_i` edge only when control bit 31 is 1 and control bits 19:15 equal 1. Otherwise it holds.
- R6: When `pc0_we_i` or `pc1_we_i` is high, that counter takes its write data on that edge, whatever the values of `tick_i` and the control register.
- R7: `tmr_req_o` is high exactly when `irq_en_i` is 1 and compare <= count < compare + 1000, with unsigned compares and an upper bound computed one bit wider, so that it never wraps.
- R8: `tmr_cause_o` is 0x808000 while `tmr_req_o` is high and 0 otherwise.
- R9: Writes to compare (`cmp_we_i`) and control (`pctl_we_i`) take effect on the next edge. The request is a level, so a compare write that moves the window away from the count drops it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Cycle-advance strobe |
| irq_en_i | input | 1 | Timer interrupt mask bit |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write data |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 32 | Compare write data |
| pctl_we_i | input | 1 | Event-control write strobe |
| pctl_wdata_i | input | 32 | Event-control write data |
| pc0_we_i | input | 1 | Event counter 0 write strobe |
| pc0_wdata_i | input | 32 | Event counter 0 write data |
| pc1_we_i | input | 1 | Event counter 1 write strobe |
| pc1_wdata_i | input | 32 | Event counter 1 write data |
| count_o | output | 32 | Cycle counter value |
| compare_o | output | 32 | Compare register value |
| pctl_o | output | 32 | Event-control register value |
| pc0_o | output | 32 | Event counter 0 value |
| pc1_o | output | 32 | Event counter 1 value |
| tmr_req_o | output | 1 | Timer request level |
| tmr_cause_o | output | 32 | Cause code for the timer request |

## Verification
The collision that matters is a software write landing in the same cycle as an advance strobe, for the main counter and for each event counter. The bench raises both in one cycle, with the event select set to match, and expects the written value rather than the written value plus one. The second overlap is a compare rewrite while the request is high: the bench expects the request to drop one cycle later. A sweep of the count across both window edges, including a compare near the top of the range, confirms the bound does not wrap.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int CTL_W      = 32;
  localparam int SEL_W      = 5;
  localparam int EN_BIT     = 31;
  localparam int NUM_PERF   = 2;
  localparam int SEL_MATCH  = 1;

  // select-field low bit for each event counter
  function automatic int sel_lsb(input int idx);
    return (idx == 0) ? 5 : 15;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= '0;
    else if (we_i)  val_q <= wdata_i;
    else if (inc_i) val_q <= val_q + W'(1);
  end

  assign value_o = val_q;
endmodule

// File: rtl/evt_gate.sv
module evt_gate #(
  parameter int CTL_W  = 32,
  parameter int EN_POS = 31,
  parameter int LSB    = 5,
  parameter int SEL_W  = 5,
  parameter int MATCH  = 1
) (
  input  logic [CTL_W-1:0] ctl_i,
  output logic             hit_o
);
  assign hit_o = ctl_i[EN_POS] && (ctl_i[LSB +: SEL_W] == SEL_W'(MATCH));
endmodule

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int W    = 32,
  parameter int SPAN = 1000
) (
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] cmp_i,
  input  logic         en_i,
  output logic         hit_o
);
  logic [W:0] upper;
  assign upper = {1'b0, cmp_i} + (W+1)'(SPAN);
  assign hit_o = en_i && (count_i >= cmp_i) && ({1'b0, count_i} < upper);
endmodule

// File: rtl/cop_timer_unit.sv
module cop_timer_unit
  import ctr_pkg::*;
#(
  parameter int          W     = 32,
  parameter int          SPAN  = 1000,
  parameter logic [31:0] CAUSE = 32'h0080_8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             irq_en_i,
  input  logic             cnt_we_i,
  input  logic [W-1:0]     cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [W-1:0]     cmp_wdata_i,
  input  logic             pctl_we_i,
  input  logic [CTL_W-1:0] pctl_wdata_i,
  input  logic             pc0_we_i,
  input  logic [W-1:0]     pc0_wdata_i,
  input  logic             pc1_we_i,
  input  logic [W-1:0]     pc1_wdata_i,
  output logic [W-1:0]     count_o,
  output logic [W-1:0]     compare_o,
  output logic [CTL_W-1:0] pctl_o,
  output logic [W-1:0]     pc0_o,
  output logic [W-1:0]     pc1_o,
  output logic             tmr_req_o,
  output logic [31:0]      tmr_cause_o
);
  logic [W-1:0]     cmp_q;
  logic [CTL_W-1:0] pctl_q;
  logic [W-1:0]     count_w;
  logic             win_hit;

  logic [NUM_PERF-1:0] pc_we;
  logic [W-1:0]        pc_wd  [NUM_PERF];
  logic [W-1:0]        pc_val [NUM_PERF];

  assign pc_we    = {pc1_we_i, pc0_we_i};
  assign pc_wd[0] = pc0_wdata_i;
  assign pc_wd[1] = pc1_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      pctl_q <= '0;
    end else begin
      if (cmp_we_i)  cmp_q  <= cmp_wdata_i;
      if (pctl_we_i) pctl_q <= pctl_wdata_i;
    end
  end

  evt_counter #(.W(W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (tick_i),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .value_o (count_w)
  );

  for (genvar g = 0; g < NUM_PERF; g++) begin : g_perf
    logic sel_hit;
    evt_gate #(
      .CTL_W  (CTL_W),
      .EN_POS (EN_BIT),
      .LSB    (sel_lsb(g)),
      .SEL_W  (SEL_W),
      .MATCH  (SEL_MATCH)
    ) u_gate (
      .ctl_i (pctl_q),
      .hit_o (sel_hit)
    );
    evt_counter #(.W(W)) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (tick_i && sel_hit),
      .we_i    (pc_we[g]),
      .wdata_i (pc_wd[g]),
      .value_o (pc_val[g])
    );
  end

  win_cmp #(.W(W), .SPAN(SPAN)) u_win (
    .count_i (count_w),
    .cmp_i   (cmp_q),
    .en_i    (irq_en_i),
    .hit_o   (win_hit)
  );

  assign count_o     = count_w;
  assign compare_o   = cmp_q;
  assign pctl_o      = pctl_q;
  assign pc0_o       = pc_val[0];
  assign pc1_o       = pc_val[1];
  assign tmr_req_o   = win_hit;
  assign tmr_cause_o = win_hit ? CAUSE : 32'h0;
endmodule

// File: rtl/cop_timer_chk.sv
module cop_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         irq_en_i,
  input logic         cnt_we_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic         pc0_we_i,
  input logic [W-1:0] pc0_wdata_i,
  input logic         pc1_we_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] compare_o,
  input logic [31:0]  pctl_o,
  input logic [W-1:0] pc0_o,
  input logic [W-1:0] pc1_o,
  input logic         tmr_req_o,
  input logic [31:0]  tmr_cause_o
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_we_i) |=> count_o == $past(count_o) + W'(1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_we_i) |=> $stable(count_o));

  // R3
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> count_o == $past(cnt_wdata_i));

  // R4
  pc0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc0_we_i && !(tick_i && pctl_o[31] && pctl_o[9:5] == 5'd1)) |=> $stable(pc0_o));

  // R5
  pc1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc1_we_i && !(tick_i && pctl_o[31] && pctl_o[19:15] == 5'd1)) |=> $stable(pc1_o));

  // R6
  pc0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc0_we_i |=> pc0_o == $past(pc0_wdata_i));

  // R7
  req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req_o |-> (irq_en_i && count_o >= compare_o));

  // R8
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req_o ? (tmr_cause_o == 32'h0080_8000) : (tmr_cause_o == 32'h0));
endmodule

bind cop_timer_unit cop_timer_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .irq_en_i    (irq_en_i),
  .cnt_we_i    (cnt_we_i),
  .cnt_wdata_i (cnt_wdata_i),
  .pc0_we_i    (pc0_we_i),
  .pc0_wdata_i (pc0_wdata_i),
  .pc1_we_i    (pc1_we_i),
  .count_o     (count_o),
  .compare_o   (compare_o),
  .pctl_o      (pctl_o),
  .pc0_o       (pc0_o),
  .pc1_o       (pc1_o),
  .tmr_req_o   (tmr_req_o),
  .tmr_cause_o (tmr_cause_o)
);

// File: tb/test_cop_timer_unit.sv
module test_cop_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, irq_en_i = 1'b0;
  logic        cnt_we_i = 1'b0, cmp_we_i = 1'b0, pctl_we_i = 1'b0;
  logic        pc0_we_i = 1'b0, pc1_we_i = 1'b0;
  logic [31:0] cnt_wdata_i = '0, cmp_wdata_i = '0, pctl_wdata_i = '0;
  logic [31:0] pc0_wdata_i = '0, pc1_wdata_i = '0;
  logic [31:0] count_o, compare_o, pctl_o, pc0_o, pc1_o, tmr_cause_o;
  logic        tmr_req_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_timer_unit i_cop_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .irq_en_i(irq_en_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .pctl_we_i(pctl_we_i), .pctl_wdata_i(pctl_wdata_i),
    .pc0_we_i(pc0_we_i), .pc0_wdata_i(pc0_wdata_i),
    .pc1_we_i(pc1_we_i), .pc1_wdata_i(pc1_wdata_i),
    .count_o(count_o), .compare_o(compare_o), .pctl_o(pctl_o),
    .pc0_o(pc0_o), .pc1_o(pc1_o), .tmr_req_o(tmr_req_o), .tmr_cause_o(tmr_cause_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // apply the staged inputs for one edge, then release strobes
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tick_i = 0; cnt_we_i = 0; cmp_we_i = 0; pctl_we_i = 0; pc0_we_i = 0; pc1_we_i = 0;
  endtask

  function automatic logic exp_req(input logic [31:0] c, input logic [31:0] m, input logic en);
    logic [32:0] up;
    up = {1'b0, m} + 33'd1000;
    return en && (c >= m) && ({1'b0, c} < up);
  endfunction

  task automatic set_count(input logic [31:0] v);
    cnt_we_i = 1; cnt_wdata_i = v; step();
  endtask

  task automatic check_window(input string req, input logic [31:0] c, input logic [31:0] m);
    logic e;
    set_count(c);
    e = exp_req(c, m, irq_en_i);
    chk(req, {31'b0, tmr_req_o}, {31'b0, e});
    chk("R8", tmr_cause_o, e ? 32'h0080_8000 : 32'h0);
  endtask

  initial begin
    logic [31:0] exp_c;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset values
    chk("R1", count_o, 0); chk("R1", compare_o, 0); chk("R1", pctl_o, 0);
    chk("R1", pc0_o, 0); chk("R1", pc1_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 stepping with ticks interleaved with idle cycles
    exp_c = 0;
    for (int i = 0; i < 24; i++) begin
      tick_i = (i % 3 != 1);
      if (tick_i) exp_c++;
      step();
      chk("R2", count_o, exp_c);
    end
    // R2 wrap
    set_count(32'hFFFF_FFFF);
    tick_i = 1; step();
    chk("R2", count_o, 32'h0);

    // R3 write beats tick in the same cycle
    tick_i = 1; cnt_we_i = 1; cnt_wdata_i = 32'h1234_5678; step();
    chk("R3", count_o, 32'h1234_5678);

    // R4/R5 sweep both select fields and enable
    for (int en = 0; en < 2; en++) begin
      for (int sel = 0; sel < 32; sel++) begin
        pctl_we_i = 1;
        pctl_wdata_i = (32'(en) << 31) | (32'(sel) << 15) | (32'(sel) << 5);
        pc0_we_i = 1; pc0_wdata_i = 0; pc1_we_i = 1; pc1_wdata_i = 0;
        step();
        for (int k = 0; k < 3; k++) begin tick_i = 1; step(); end
        step();
        chk("R4", pc0_o, (en == 1 && sel == 1) ? 32'd3 : 32'd0);
        chk("R5", pc1_o, (en == 1 && sel == 1) ? 32'd3 : 32'd0);
      end
    end
    // R4 unrelated control bits set, only counter 0 selected
    pctl_we_i = 1; pctl_wdata_i = 32'h8000_7C20;
    pc0_we_i = 1; pc0_wdata_i = 10; pc1_we_i = 1; pc1_wdata_i = 20; step();
    tick_i = 1; step(); tick_i = 1; step();
    chk("R4", pc0_o, 12); chk("R5", pc1_o, 20);
    // R6 writes beat a matching tick
    pctl_we_i = 1; pctl_wdata_i = 32'h8000_8020; step();
    tick_i = 1; pc0_we_i = 1; pc0_wdata_i = 32'hAAAA_0001;
    pc1_we_i = 1; pc1_wdata_i = 32'h5555_0002; step();
    chk("R6", pc0_o, 32'hAAAA_0001); chk("R6", pc1_o, 32'h5555_0002);
    tick_i = 1; step();
    chk("R5", pc1_o, 32'h5555_0003);

    // R7 window sweep around both edges
    irq_en_i = 1;
    cmp_we_i = 1; cmp_wdata_i = 100; step();
    for (int c = 95; c <= 105; c++) check_window("R7", 32'(c), 100);
    for (int c = 1095; c <= 1105; c++) check_window("R7", 32'(c), 100);
    check_window("R7", 0, 100);
    check_window("R7", 32'd50000, 100);
    irq_en_i = 0;
    check_window("R7", 100, 100);
    irq_en_i = 1;
    // R7 upper bound does not wrap
    cmp_we_i = 1; cmp_wdata_i = 32'hFFFF_FF00; step();
    check_window("R7", 32'hFFFF_FFFF, 32'hFFFF_FF00);
    check_window("R7", 32'h0000_0010, 32'hFFFF_FF00);

    // R9 compare rewrite drops the request one cycle later
    cmp_we_i = 1; cmp_wdata_i = 100; step();
    set_count(150);
    chk("R9", {31'b0, tmr_req_o}, 1);
    cmp_we_i = 1; cmp_wdata_i = 200; step();
    chk("R9", {31'b0, tmr_req_o}, 0);
    chk("R9", compare_o, 200);
    // R7 ticking into the window
    set_count(198);
    tick_i = 1; step(); chk("R7", {31'b0, tmr_req_o}, 0);
    tick_i = 1; step(); chk("R7", {31'b0, tmr_req_o}, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule